// File: doc/BRIEF.md
# SPI Flash Status Polling Engine

This block waits for a serial flash device to finish an internal operation. It repeatedly asks an external transaction sequencer to read the device's status register, until the returned value passes a masked compare or a time budget runs out. The command opcode, the status length (one or two bytes), a 16-bit mask, a 16-bit expected value, an initial delay, a polling interval and a timeout are all captured when a poll is started.

Delays are measured in pulses of a free-running microsecond tick input. The timeout is measured in milliseconds, and each millisecond is a parameterised number of ticks. For every read, the engine pulses a request to the sequencer and collects the returned bytes from a valid-qualified byte stream. It then waits for the sequencer's completion strobe before it evaluates the status. The end of a poll is a single-cycle completion pulse, which carries a success or timeout flag and the last status value read.

Top module: `spi_stat_poll`

## Requirements
- R1: A poll ends with `done` high for one cycle and `ok`=1, `timed_out`=0 at the first read whose status S satisfies (S & mask) == match.
- R2: With `cmd_two_byte`=1, the first received byte becomes status bits 7:0 and the second becomes bits 15:8. With `cmd_two_byte`=0, the single byte is zero-extended to 16 bits.
- R3: After start is accepted, exactly `init_delay_us` tick pulses pass before the first read request, where each pulse is counted at the clock edge that samples it. A value of 0 requests the first read at once.
- R4: After each non-matching read completes, exactly `interval_us` tick pulses pass before the next read request.
- R5: The timeout expires after `timeout_ms` × TICKS_PER_MS tick pulses, counted from start. An expiry seen while waiting ends the poll with `timed_out`=1 and `ok`=0. A timeout of 0 ends the poll with no read, and `last_status` is then 0.
- R6: A read that is in flight when the timeout expires runs to completion and is evaluated first. A match still gives `ok`=1; otherwise the poll ends with `timed_out`=1 after that read.
- R7: On either outcome, `last_status` shows the status of the last read and changes only in a cycle where `done` is high.
- R8: `busy` is high from the cycle after start is accepted until `done` rises, and it is low in the `done` cycle. A `start` while busy is ignored, and all descriptor inputs are sampled only at an accepted start.
- R9: `seq_start` is a single-cycle pulse for each read, issued only while busy. `seq_opcode` and `seq_two_byte` carry the captured opcode and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a poll (accepted when idle) |
| cmd_opcode | input | 8 | Status-read opcode |
| cmd_two_byte | input | 1 | 1: 2-byte status, 0: 1-byte status |
| mask | input | 16 | Compare mask |
| match | input | 16 | Expected masked value |
| init_delay_us | input | TW | Delay before the first read, in ticks |
| interval_us | input | TW | Delay between reads, in ticks |
| timeout_ms | input | TW | Overall budget in milliseconds |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Condition met (valid at done, held) |
| timed_out | output | 1 | Budget exhausted (valid at done, held) |
| last_status | output | 16 | Last status read |
| seq_start | output | 1 | Read request pulse to the sequencer |
| seq_opcode | output | 8 | Opcode for the sequencer |
| seq_two_byte | output | 1 | Status length for the sequencer |
| seq_rx_valid | input | 1 | Received byte valid |
| seq_rx_byte | input | 8 | Received byte |
| seq_done | input | 1 | Sequencer transaction complete (after the last byte) |

## Verification
A corrupted delay counter shows up as a wrong number of tick pulses between a completion strobe and the next `seq_start`. It is visible at the very next request, so the bench counts tick pulses in every waiting window. A wrong byte-lane pointer or a stale status register shows in `last_status` at the next `done`. A mis-latched mask or match value shows as the wrong number of reads before `done`, or as an early success. Faults in the millisecond counter appear only when the budget runs out, so two polls are placed so that expiry falls inside a read. Those polls check that exactly one read is made, followed by the correct outcome.

// File: rtl/spi_stat_poll.sv
module spi_stat_poll #(
  parameter int TW = 16,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          start,
  input  logic [7:0]    cmd_opcode,
  input  logic          cmd_two_byte,
  input  logic [15:0]   mask,
  input  logic [15:0]   match,
  input  logic [TW-1:0] init_delay_us,
  input  logic [TW-1:0] interval_us,
  input  logic [TW-1:0] timeout_ms,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          timed_out,
  output logic [15:0]   last_status,
  output logic          seq_start,
  output logic [7:0]    seq_opcode,
  output logic          seq_two_byte,
  input  logic          seq_rx_valid,
  input  logic [7:0]    seq_rx_byte,
  input  logic          seq_done
);
  localparam int SW = $clog2(TICKS_PER_MS + 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(TICKS_PER_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_READ} st_t;

  st_t           st;
  logic [7:0]    op_q;
  logic          two_q;
  logic [15:0]   msk_q, mt_q, rd_stat;
  logic [TW-1:0] ivl_q, to_q, dly, ms;
  logic [SW-1:0] sub;
  logic          byte_hi;
  logic          expired, hit;

  assign expired      = (ms >= to_q);
  assign hit          = ((rd_stat & msk_q) == mt_q);
  assign busy         = (st != S_IDLE);
  assign seq_start    = (st == S_ISSUE);
  assign seq_opcode   = op_q;
  assign seq_two_byte = two_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_q        <= '0;
      two_q       <= 1'b0;
      msk_q       <= '0;
      mt_q        <= '0;
      ivl_q       <= '0;
      to_q        <= '0;
      dly         <= '0;
      ms          <= '0;
      sub         <= '0;
      rd_stat     <= '0;
      byte_hi     <= 1'b0;
      done        <= 1'b0;
      ok          <= 1'b0;
      timed_out   <= 1'b0;
      last_status <= '0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && tick_us && !expired) begin
        if (sub == SUB_LAST) begin
          sub <= '0;
          ms  <= ms + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          op_q    <= cmd_opcode;
          two_q   <= cmd_two_byte;
          msk_q   <= mask;
          mt_q    <= match;
          ivl_q   <= interval_us;
          to_q    <= timeout_ms;
          dly     <= init_delay_us;
          sub     <= '0;
          ms      <= '0;
          rd_stat <= '0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (expired) begin
            done        <= 1'b1;
            ok          <= 1'b0;
            timed_out   <= 1'b1;
            last_status <= rd_stat;
            st          <= S_IDLE;
          end else if (dly == '0) begin
            st <= S_ISSUE;
          end else if (tick_us) begin
            dly <= dly - 1'b1;
          end
        end
        S_ISSUE: begin
          rd_stat <= '0;
          byte_hi <= 1'b0;
          st      <= S_READ;
        end
        S_READ: begin
          if (seq_rx_valid) begin
            if (byte_hi) rd_stat[15:8] <= seq_rx_byte;
            else         rd_stat[7:0]  <= seq_rx_byte;
            byte_hi <= 1'b1;
          end
          if (seq_done) begin
            if (hit || expired) begin
              done        <= 1'b1;
              ok          <= hit;
              timed_out   <= !hit;
              last_status <= rd_stat;
              st          <= S_IDLE;
            end else begin
              dly <= ivl_q;
              st  <= S_WAIT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_stat_poll_chk.sv
module spi_stat_poll_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        ok,
  input logic        timed_out,
  input logic [15:0] last_status,
  input logic        seq_start,
  input logic [15:0] msk,
  input logic [15:0] mt,
  input logic        expired
);
  // R1
  ok_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> ((last_status & msk) == mt));
  // R5
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != timed_out));
  // R5
  tout_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> expired);
  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_status) |-> done);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);
  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> busy);
endmodule

bind spi_stat_poll spi_stat_poll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ok(ok),
  .timed_out(timed_out), .last_status(last_status), .seq_start(seq_start),
  .msk(msk_q), .mt(mt_q), .expired(expired)
);

// File: tb/spi_stat_poll_test.sv
module spi_stat_poll_test;
  localparam int TW = 16;
  localparam int TPM = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, start = 1'b0;
  logic [7:0] cmd_opcode = '0;
  logic cmd_two_byte = 1'b0;
  logic [15:0] mask = '0, match = '0;
  logic [TW-1:0] init_delay_us = '0, interval_us = '0, timeout_ms = '0;
  logic busy, done, ok, timed_out, seq_start, seq_two_byte;
  logic [15:0] last_status;
  logic [7:0] seq_opcode;
  logic seq_rx_valid = 1'b0, seq_done = 1'b0;
  logic [7:0] seq_rx_byte = '0;

  always #4 clk = ~clk;

  spi_stat_poll #(.TW(TW), .TICKS_PER_MS(TPM)) uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
    .cmd_opcode(cmd_opcode), .cmd_two_byte(cmd_two_byte), .mask(mask),
    .match(match), .init_delay_us(init_delay_us), .interval_us(interval_us),
    .timeout_ms(timeout_ms), .busy(busy), .done(done), .ok(ok),
    .timed_out(timed_out), .last_status(last_status), .seq_start(seq_start),
    .seq_opcode(seq_opcode), .seq_two_byte(seq_two_byte),
    .seq_rx_valid(seq_rx_valid), .seq_rx_byte(seq_rx_byte), .seq_done(seq_done)
  );

  typedef struct {logic e_ok; logic [15:0] e_st; string tag;} exp_t;
  exp_t exp_q[$];
  logic [15:0] resp_q[$];
  logic [15:0] dflt = 16'hBEEF;
  int gaps[$];
  int n_chk = 0, n_fail = 0, n_reads = 0, n_done = 0;
  logic [7:0] seen_op = '0;

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    repeat (3) @(negedge clk);
    tick_us = 1'b1;
    @(negedge clk);
    tick_us = 1'b0;
  end

  // sequencer model
  initial forever begin
    @(posedge clk); #1;
    if (seq_start) begin
      logic [15:0] s;
      logic two;
      n_reads++;
      seen_op = seq_opcode;
      two = seq_two_byte;
      s = (resp_q.size() > 0) ? resp_q.pop_front() : dflt;
      @(posedge clk);
      @(negedge clk); seq_rx_valid = 1'b1; seq_rx_byte = s[7:0];
      if (two) begin @(negedge clk); seq_rx_byte = s[15:8]; end
      @(negedge clk); seq_rx_valid = 1'b0;
      @(negedge clk); seq_done = 1'b1;
      @(negedge clk); seq_done = 1'b0;
    end
  end

  // monitor: gap counting and result scoreboard
  initial begin
    bit win = 1'b0;
    int cnt = 0;
    forever begin
      @(negedge clk); #1;
      if (!busy && start && rst_n) begin win = 1'b1; cnt = 0; end
      else if (win) begin
        if (seq_start) begin gaps.push_back(cnt); win = 1'b0; end
        else if (tick_us) cnt++;
      end
      if (seq_done) begin win = 1'b1; cnt = 0; end
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(ok == e.e_ok, {e.tag, " ok"}, ok, e.e_ok);
          check(timed_out == !e.e_ok, {e.tag, " R5 timed_out"}, timed_out, !e.e_ok);
          check(last_status == e.e_st, {e.tag, " R7 last_status"}, last_status, e.e_st);
          check(!busy, {e.tag, " R8 busy low at done"}, busy, 0);
        end
        n_done++;
      end
    end
  end

  task automatic run_poll(input logic [7:0] op, input logic two, input logic [15:0] m, mt,
                          input int idly, ivl, tms, input logic e_ok, input logic [15:0] e_st,
                          input int e_reads, input logic poke, input string tag);
    int k = n_done;
    gaps.delete();
    n_reads = 0;
    exp_q.push_back('{e_ok, e_st, tag});
    @(negedge clk);
    start = 1'b1; cmd_opcode = op; cmd_two_byte = two; mask = m; match = mt;
    init_delay_us = TW'(idly); interval_us = TW'(ivl); timeout_ms = TW'(tms);
    @(negedge clk);
    start = 1'b0;
    #1 check(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; cmd_opcode = 8'h77; mask = 16'h0; match = 16'h0;
      init_delay_us = '0; interval_us = '0;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done == k + 1);
    repeat (2) @(negedge clk);
    if (e_reads >= 0) check(n_reads == e_reads, {tag, " read count"}, n_reads, e_reads);
    if (n_reads > 0) begin
      check(seen_op == op, {tag, " R9 opcode"}, seen_op, op);
      check(gaps[0] == idly, {tag, " R3 initial delay ticks"}, gaps[0], idly);
      for (int i = 1; i < gaps.size(); i++)
        check(gaps[i] == ivl, {tag, " R4 interval ticks"}, gaps[i], ivl);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !done && !seq_start && last_status == 16'h0, "reset state", busy, 0);
    // R1 R2: two-byte match on first read, low byte first
    resp_q = '{16'h1234};
    run_poll(8'h05, 1'b1, 16'hFFFF, 16'h1234, 3, 2, 50, 1'b1, 16'h1234, 1, 1'b0, "R1 R2 two-byte");
    // R2 R4: one-byte zero extension, success on third read
    resp_q = '{16'h5501, 16'h5501, 16'h5580};
    run_poll(8'h70, 1'b0, 16'h0001, 16'h0000, 2, 4, 50, 1'b1, 16'h0080, 3, 1'b0, "R2 R4 one-byte");
    // R3: zero initial delay
    resp_q = '{16'hA0A0};
    run_poll(8'h0F, 1'b1, 16'h00F0, 16'h00A0, 0, 1, 50, 1'b1, 16'hA0A0, 1, 1'b0, "R3 zero delay");
    // R5 R7: timeout after waiting, last status kept
    resp_q.delete(); dflt = 16'hBEEF;
    run_poll(8'h05, 1'b1, 16'h0001, 16'h0000, 1, 1, 2, 1'b0, 16'hBEEF, -1, 1'b0, "R5 timeout");
    // R5: zero timeout, no read
    run_poll(8'h05, 1'b1, 16'h0000, 16'h0000, 0, 0, 0, 1'b0, 16'h0000, 0, 1'b0, "R5 zero timeout");
    // R6: expiry during read, matching status still succeeds
    resp_q = '{16'h00A5};
    run_poll(8'h05, 1'b1, 16'h00FF, 16'h00A5, 9, 0, 1, 1'b1, 16'h00A5, 1, 1'b0, "R6 in-flight match");
    // R6: expiry during read, mismatch ends after exactly one read
    resp_q = '{16'h0011};
    run_poll(8'h05, 1'b1, 16'h00FF, 16'h00A5, 9, 0, 1, 1'b0, 16'h0011, 1, 1'b0, "R6 in-flight miss");
    // R8: start while busy ignored, descriptor latched
    resp_q = '{16'h0F00, 16'h0FF0};
    run_poll(8'h35, 1'b1, 16'h00F0, 16'h00F0, 6, 3, 50, 1'b1, 16'h0FF0, 2, 1'b1, "R8 busy start");
    check(exp_q.size() == 0, "R8 one done per poll", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule